// File: doc/BRIEF.md
# Wraparound Mesh Routing Sequencer

This block moves data between the lanes of a one-dimensional array of `N_LANES` lanes. Each lane holds one routing register, and the lanes are wired as a ring in which every lane reaches its neighbours one lane away and `LONG_HOP` lanes away, in both directions. The ends wrap around. With the default 64 lanes, lane 63 is wired to lanes 0, 62, 7 and 55.

A routing instruction loads every lane's value and asks for one signed shift distance that applies to all lanes. The sequencer reduces the distance modulo the lane count. It then splits the distance into the shortest series of single-hop moves of ±1 and ±`LONG_HOP`. It performs one hop per clock, and on each hop all lane registers shift together. After the last hop it writes the routed values into the destination registers of the lanes that were enabled, and it pulses done. Long hops run before short hops. When two decompositions have equal cost, the one with the positive short part wins.

Top module: `mesh_route_seq`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and every destination lane in `dest_o` is zero.
- R2: `dist_i` is a two's complement value taken modulo `N_LANES`. For 64 lanes, -1 (all ones) gives the same result as +63.
- R3: A route by distance d leaves lane j of `dest_o` (bits j*LANE_W upward) holding the lane (j - d) mod N_LANES value of `lane_i` that was captured at start. Lane numbering wraps at both ends.
- R4: The number of busy cycles equals the fewest hops of +1, -1, +LONG_HOP and -LONG_HOP whose sum is congruent to d modulo N_LANES. One hop is made per clock.
- R5: With 64 lanes and a long hop of 8, no distance takes more than 7 hop cycles.
- R6: A distance of 1 or -1 completes in a single hop cycle.
- R7: A distance of 0 raises `done_o` in the cycle after start, with no busy cycle.
- R8: `done_o` is high for exactly one cycle, and `busy_o` is low whenever `done_o` is high.
- R9: Only lanes whose `lane_en_i` bit was 1 at start take the routed value. Disabled lanes keep their previous destination value.
- R10: A start request raised while `busy_o` is high is ignored. The route in progress finishes with its own distance, data and step count.
- R11: `dest_o` changes only in the cycle in which `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a route when the block is idle |
| dist_i | input | $clog2(N_LANES) | Signed routing distance, two's complement |
| lane_i | input | N_LANES*LANE_W | Lane values captured at start, lane j at bits j*LANE_W |
| lane_en_i | input | N_LANES | Per-lane destination write enable, captured at start |
| busy_o | output | 1 | High during hop cycles |
| done_o | output | 1 | One-cycle pulse when the route is finished |
| dest_o | output | N_LANES*LANE_W | Destination registers of all lanes |

## Verification
The bench runs every distance from 0 to 63 and several negative ones. It compares the routed vector with a modular-shift model and the hop count with a brute-force search for the fewest hops. A wrong wrap direction or a shift off by one lane shows up as a data miscompare. A decomposition that does not reach the minimum, such as one that never takes the negative long hop, is caught by the busy-cycle count. Separate tests check that a zero distance finishes at once, that a start raised mid-route does not overwrite the route in progress, and that disabled lanes keep their old value. A design that failed to latch the enable mask at start would corrupt those disabled lanes.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;
    typedef enum logic [1:0] {
        HOP_P1 = 2'd0,
        HOP_M1 = 2'd1,
        HOP_PL = 2'd2,
        HOP_ML = 2'd3
    } hop_e;
endpackage

// File: rtl/mesh_route_planner.sv
module mesh_route_planner #(
    parameter int N_LANES  = 64,
    parameter int LONG_HOP = 8,
    localparam int DW = $clog2(N_LANES),
    localparam int CW = DW + 1
) (
    input  logic [DW-1:0] dist_i,
    output logic [CW-1:0] long_mag_o,
    output logic          long_neg_o,
    output logic [CW-1:0] short_mag_o,
    output logic          short_neg_o
);
    localparam int LB = $clog2(LONG_HOP);
    localparam int MW = DW - LB;
    localparam int M  = N_LANES / LONG_HOP;

    logic [MW-1:0] q1, q2;
    logic [LB-1:0] r;
    logic [CW-1:0] q1w, q2w, rw, mag1, mag2, smag2, cost1, cost2;
    logic          neg1, neg2, take2;

    always_comb begin
        q1    = dist_i[DW-1:LB];
        r     = dist_i[LB-1:0];
        q2    = q1 + 1'b1;
        q1w   = CW'(q1);
        q2w   = CW'(q2);
        rw    = CW'(r);
        // long count as a signed ring offset, ties kept positive
        neg1  = q1w > CW'(M / 2);
        neg2  = q2w > CW'(M / 2);
        mag1  = neg1 ? CW'(M) - q1w : q1w;
        mag2  = neg2 ? CW'(M) - q2w : q2w;
        smag2 = CW'(LONG_HOP) - rw;
        cost1 = mag1 + rw;
        cost2 = mag2 + smag2;
        take2 = (rw != '0) && (cost2 < cost1);
        long_mag_o  = take2 ? mag2 : mag1;
        long_neg_o  = take2 ? neg2 : neg1;
        short_mag_o = take2 ? smag2 : rw;
        short_neg_o = take2;
    end
endmodule

// File: rtl/mesh_shift_net.sv
module mesh_shift_net
    import mesh_route_pkg::*;
#(
    parameter int N_LANES  = 64,
    parameter int LANE_W   = 8,
    parameter int LONG_HOP = 8,
    localparam int VW = N_LANES * LANE_W
) (
    input  logic [VW-1:0] vec_i,
    input  hop_e          hop_i,
    output logic [VW-1:0] vec_o
);
    for (genvar j = 0; j < N_LANES; j++) begin : g_lane
        localparam int SRC_P1 = (j - 1 + N_LANES) % N_LANES;
        localparam int SRC_M1 = (j + 1) % N_LANES;
        localparam int SRC_PL = (j - LONG_HOP + N_LANES) % N_LANES;
        localparam int SRC_ML = (j + LONG_HOP) % N_LANES;
        always_comb begin
            unique case (hop_i)
                HOP_P1:  vec_o[j*LANE_W +: LANE_W] = vec_i[SRC_P1*LANE_W +: LANE_W];
                HOP_M1:  vec_o[j*LANE_W +: LANE_W] = vec_i[SRC_M1*LANE_W +: LANE_W];
                HOP_PL:  vec_o[j*LANE_W +: LANE_W] = vec_i[SRC_PL*LANE_W +: LANE_W];
                default: vec_o[j*LANE_W +: LANE_W] = vec_i[SRC_ML*LANE_W +: LANE_W];
            endcase
        end
    end
endmodule

// File: rtl/mesh_route_seq.sv
module mesh_route_seq
    import mesh_route_pkg::*;
#(
    parameter int N_LANES  = 64,
    parameter int LANE_W   = 8,
    parameter int LONG_HOP = 8,
    localparam int DW = $clog2(N_LANES),
    localparam int VW = N_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic signed [DW-1:0] dist_i,
    input  logic [VW-1:0]        lane_i,
    input  logic [N_LANES-1:0]   lane_en_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [VW-1:0]        dest_o
);
    localparam int CW       = DW + 1;
    localparam int M        = N_LANES / LONG_HOP;
    localparam int MAX_HOPS = M / 2 + LONG_HOP / 2 - 1;

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [CW-1:0]      long_left;
        logic               long_neg;
        logic [CW-1:0]      short_left;
        logic               short_neg;
        logic [VW-1:0]      rte;
        logic [N_LANES-1:0] en;
        logic [VW-1:0]      dest;
    } seq_t;

    seq_t st_d, st_q;

    logic [CW-1:0] p_long, p_short;
    logic          p_long_neg, p_short_neg;
    hop_e          hop;
    logic [VW-1:0] shifted;
    logic          last_hop, accept;

    mesh_route_planner #(.N_LANES(N_LANES), .LONG_HOP(LONG_HOP)) u_plan (
        .dist_i      (dist_i),
        .long_mag_o  (p_long),
        .long_neg_o  (p_long_neg),
        .short_mag_o (p_short),
        .short_neg_o (p_short_neg)
    );

    always_comb begin
        if (st_q.long_left != '0) hop = st_q.long_neg ? HOP_ML : HOP_PL;
        else                      hop = st_q.short_neg ? HOP_M1 : HOP_P1;
    end

    mesh_shift_net #(.N_LANES(N_LANES), .LANE_W(LANE_W), .LONG_HOP(LONG_HOP)) u_net (
        .vec_i (st_q.rte),
        .hop_i (hop),
        .vec_o (shifted)
    );

    assign accept   = start_i && !st_q.busy;
    assign last_hop = ((st_q.long_left == '0) && (st_q.short_left == CW'(1))) ||
                      ((st_q.long_left == CW'(1)) && (st_q.short_left == '0));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.rte        = lane_i;
            st_d.en         = lane_en_i;
            st_d.long_left  = p_long;
            st_d.long_neg   = p_long_neg;
            st_d.short_left = p_short;
            st_d.short_neg  = p_short_neg;
            if ((p_long == '0) && (p_short == '0)) begin
                st_d.done = 1'b1;
                for (int j = 0; j < N_LANES; j++)
                    if (lane_en_i[j]) st_d.dest[j*LANE_W +: LANE_W] = lane_i[j*LANE_W +: LANE_W];
            end else begin
                st_d.busy = 1'b1;
            end
        end else if (st_q.busy) begin
            st_d.rte = shifted;
            if (st_q.long_left != '0) st_d.long_left  = st_q.long_left - 1'b1;
            else                      st_d.short_left = st_q.short_left - 1'b1;
            if (last_hop) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                for (int j = 0; j < N_LANES; j++)
                    if (st_q.en[j]) st_d.dest[j*LANE_W +: LANE_W] = shifted[j*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign dest_o = st_q.dest;

    // hop cycles since the route was accepted, used only by the checks
    logic [CW:0] hop_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          hop_cnt_q <= '0;
        else if (accept)     hop_cnt_q <= '0;
        else if (st_q.busy)  hop_cnt_q <= hop_cnt_q + 1'b1;
    end

    a_r5_hop_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (hop_cnt_q < (CW+1)'(MAX_HOPS)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r11_dest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(dest_o));

    a_r7_zero_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (dist_i == '0)) |=> (done_o && !busy_o));

    a_r10_busy_keeps_going: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> (busy_o || done_o));
endmodule

// File: tb/tb_mesh_route_seq.sv
module tb_mesh_route_seq;
    localparam int N  = 64;
    localparam int W  = 8;
    localparam int L  = 8;
    localparam int VW = N * W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic signed [5:0] dist_i = '0;
    logic [VW-1:0]     lane_i = '0;
    logic [N-1:0]      lane_en_i = '0;
    logic              busy_o, done_o;
    logic [VW-1:0]     dest_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [VW-1:0] mdl = '0;

    mesh_route_seq #(.N_LANES(N), .LANE_W(W), .LONG_HOP(L)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dist_i(dist_i),
        .lane_i(lane_i), .lane_en_i(lane_en_i),
        .busy_o(busy_o), .done_o(done_o), .dest_o(dest_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int min_hops(input int dm);
        int best = 99;
        for (int a = -(N/L)/2; a <= (N/L)/2; a++)
            for (int b = -L; b <= L; b++)
                if (((((L*a + b) % N) + N) % N) == dm) begin
                    int c = (a < 0 ? -a : a) + (b < 0 ? -b : b);
                    if (c < best) best = c;
                end
        return best;
    endfunction

    // one route; inj raises a second start during the first hop cycle
    task automatic route(input int d, input logic [N-1:0] en, input int seed, input bit inj);
        int dm, k, n;
        logic [VW-1:0] src;
        dm = ((d % N) + N) % N;
        k  = min_hops(dm);
        for (int j = 0; j < N; j++) src[j*W +: W] = W'(j*37 + seed*11 + 5);
        @(negedge clk);
        start_i = 1'b1; dist_i = 6'(d); lane_i = src; lane_en_i = en;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 40) begin
            check(busy_o === 1'b1, "R4 busy during hops", busy_o, 1);
            if (inj && n == 0) begin
                start_i = 1'b1; dist_i = 6'(d + 3); lane_i = ~src; lane_en_i = ~en;
            end else begin
                start_i = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        start_i = 1'b0;
        for (int j = 0; j < N; j++)
            if (en[j]) mdl[j*W +: W] = src[(((j - dm) % N + N) % N)*W +: W];
        check(n == k, inj ? "R10 step count with late start" : "R4 step count", n, k);
        check(n <= 7, "R5 step bound", n, 7);
        if (dm == 0) check(n == 0, "R7 zero distance immediate", n, 0);
        if (dm == 1 || dm == N-1) check(n == 1, "R6 unit distance single hop", n, 1);
        check(dest_o === mdl, inj ? "R10 data with late start" : "R3 routed data",
              longint'(dest_o[63:0]), longint'(mdl[63:0]));
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0, "R8 done single pulse", done_o, 0);
        check(dest_o === mdl, "R11 dest held after done",
              longint'(dest_o[63:0]), longint'(mdl[63:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0, "R1 busy after reset", busy_o, 0);
        check(done_o === 1'b0, "R1 done after reset", done_o, 0);
        check(dest_o === '0, "R1 dest after reset", longint'(dest_o[63:0]), 0);
        rst_n = 1'b1;
        // R3 R4 R5: full sweep, all lanes enabled
        for (int d = 0; d < N; d++) route(d, '1, d, 1'b0);
        // R2: negative distances in two's complement
        route(-1, '1, 70, 1'b0);
        route(-8, '1, 71, 1'b0);
        route(-28, '1, 72, 1'b0);
        route(-32, '1, 73, 1'b0);
        // R9: partial enable masks keep old destination values
        route(5, {32{2'b01}}, 80, 1'b0);
        route(-13, {8{8'hF0}}, 81, 1'b0);
        route(0, 64'h0000_FFFF_0000_00FF, 82, 1'b0);
        route(36, 64'h8000_0000_0000_0001, 83, 1'b0);
        // R10: start during hops is ignored
        route(36, '1, 90, 1'b1);
        route(12, 64'hAAAA_5555_AAAA_5555, 91, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule